// File: doc/BRIEF.md
# Gated Frequency-to-Count Converter

This block turns a pulse-train sensor into a digital number. It counts the rising edges of an asynchronous pulse input during a counting window of a fixed number of system clocks. At the end of each window it latches the count, pulses a one-cycle strobe and starts the next window on the very next clock.

The gate length comes from the `gate_len` input. It is sampled at the start of every window. To make the highest expected sensor rate land exactly on the all-ones code, the user sets the window to Tc = (2^n − 1)/fmax. Any other rate f then reads as f·Tc, with the fraction dropped. For example, take an 8-bit count with fmax of one pulse per two clocks: a 510-clock window reads 255 at fmax. A rate ten times lower gives 25.5, which reads as 25 or 26 depending on phase. If the edges outnumber the counter, the count holds at all ones and an overflow flag is set for that window.

Control is a two-state machine. `ST_ARM` is entered on reset and loads the first gate length. The transition *start* goes from `ST_ARM` to `ST_COUNT`. In `ST_COUNT` the transition *roll* fires at each window end: it latches the result, clears the edge counter, reloads the gate and remains in `ST_COUNT`.

Top module: `pulse_rate_digitizer`

## Requirements
- R1: While `rst_n` is low, `count_out`, `count_valid` and `count_ovf` are 0. The first `count_valid` appears gate_len+1 clock edges after reset release: one arming cycle, then one full window.
- R2: `pulse_in` passes through a two-flop synchronizer and only its 0-to-1 transitions are counted. An input held high adds exactly one count in total.
- R3: A window lasts `gate_len` clock cycles, so `count_valid` pulses every `gate_len` cycles. A `gate_len` of 0 is treated as 1.
- R4: `count_valid` is high for one cycle per window. `count_out` and `count_ovf` change only on the edge that raises `count_valid`.
- R5: A periodic input whose period P clocks divides the window length G reads exactly G/P. A silent input reads 0.
- R6: For a period P that does not divide G, each window reads floor(G/P) or floor(G/P)+1. With G=510 and P=20 this is 25 or 26.
- R7: At full scale, G = (2^CNT_W − 1)·2 with one pulse every 2 clocks, the count is all ones (255 for 8 bits) and `count_ovf` is 0.
- R8: If a window sees more than 2^CNT_W − 1 edges, `count_out` reads all ones and `count_ovf` is 1. The next window without overflow reports `count_ovf` = 0.
- R9: No edge is lost or counted twice at a window boundary. Two consecutive windows together read exactly the number of edges in their combined span (51 for G=510, P=20).
- R10: A change of `gate_len` in the middle of a window does not alter that window. It takes effect from the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_in | input | 1 | Asynchronous sensor pulse train |
| gate_len | input | GATE_W | Window length in clocks, sampled at each window start |
| count_out | output | CNT_W | Edge count of the last completed window |
| count_valid | output | 1 | One-cycle strobe at each window end |
| count_ovf | output | 1 | Last window saturated |

## Verification
The assertions assume `pulse_in` stays high and stays low for at least one clock each. Shorter pulses could slip between synchronizer samples, so the edge counter could not account for them. The stimulus builds every pulse train from whole clock periods, changed on the falling edge, with a shortest period of two clocks. The assertions also assume the outputs are read only on the strobe. The bench therefore samples results at the strobe and checks held values only between strobes. Gate lengths are changed at arbitrary points to exercise R10.

// File: rtl/prd_pkg.sv
package prd_pkg;
    typedef enum logic {
        ST_ARM   = 1'b0,
        ST_COUNT = 1'b1
    } prd_state_e;
endpackage

// File: rtl/prd_sync.sv
module prd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/prd_gate_timer.sv
module prd_gate_timer #(
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [GATE_W-1:0] gate_len,
    output logic              gate_end,
    output logic              at_zero
);
    logic [GATE_W-1:0] gate_q;
    logic [GATE_W-1:0] tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= GATE_W'(1);
            tick   <= '0;
        end else if (load) begin
            gate_q <= (gate_len == '0) ? GATE_W'(1) : gate_len;
            tick   <= '0;
        end else if (run) begin
            tick   <= tick + GATE_W'(1);
        end
    end

    assign gate_end = run && (tick == gate_q - GATE_W'(1));
    assign at_zero  = (tick == '0);
endmodule

// File: rtl/prd_edge_counter.sv
module prd_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             rise,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             nxt_ovf
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_comb begin
        nxt_cnt = cnt_q;
        nxt_ovf = ovf_q;
        if (rise) begin
            if (cnt_q == FULL) nxt_ovf = 1'b1;
            else               nxt_cnt = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (en) begin
            cnt_q <= nxt_cnt;
            ovf_q <= nxt_ovf;
        end
    end
endmodule

// File: rtl/pulse_rate_digitizer.sv
module pulse_rate_digitizer
    import prd_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic [GATE_W-1:0] gate_len,
    output logic [CNT_W-1:0]  count_out,
    output logic              count_valid,
    output logic              count_ovf
);
    prd_state_e       state, state_nxt;
    logic             edge_rise;
    logic             gate_end;
    logic             timer_at_zero;
    logic             arming;
    logic             roll;
    logic [CNT_W-1:0] final_cnt;
    logic             final_ovf;

    prd_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise     (edge_rise)
    );

    assign arming = (state == ST_ARM);
    assign roll   = (state == ST_COUNT) && gate_end;

    prd_gate_timer #(.GATE_W(GATE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arming || roll),
        .run      (state == ST_COUNT),
        .gate_len (gate_len),
        .gate_end (gate_end),
        .at_zero  (timer_at_zero)
    );

    prd_edge_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (arming || roll),
        .en      (state == ST_COUNT),
        .rise    (edge_rise),
        .nxt_cnt (final_cnt),
        .nxt_ovf (final_ovf)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ARM:   state_nxt = ST_COUNT;
            ST_COUNT: state_nxt = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARM;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_out   <= '0;
            count_ovf   <= 1'b0;
            count_valid <= 1'b0;
        end else begin
            count_valid <= roll;
            if (roll) begin
                count_out <= final_cnt;
                count_ovf <= final_ovf;
            end
        end
    end
endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             timer_zero,
    input logic             count_valid,
    input logic             count_ovf,
    input logic [CNT_W-1:0] count_out
);
    // R8: a saturated window reports all ones
    p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count_ovf |-> (count_out == {CNT_W{1'b1}}));

    // R4: results move only together with the strobe
    p_out_moves_on_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count_out) || !$stable(count_ovf)) |-> count_valid);

    // R2: a detected edge is a single-cycle event
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R3: the strobe coincides with the gate timer restarting
    p_valid_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |-> timer_zero);
endmodule

bind pulse_rate_digitizer prd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (edge_rise),
    .timer_zero  (timer_at_zero),
    .count_valid (count_valid),
    .count_ovf   (count_ovf),
    .count_out   (count_out)
);

// File: tb/sim_pulse_rate_digitizer.sv
module sim_pulse_rate_digitizer;
    localparam int CNT_W  = 8;
    localparam int GATE_W = 16;
    localparam int WD     = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pulse_in = 1'b0;
    logic [GATE_W-1:0] gate_len = GATE_W'(20);
    logic [CNT_W-1:0]  count_out;
    logic              count_valid;
    logic              count_ovf;

    int nchk = 0;
    int nerr = 0;
    int per_clk = 0;
    logic hold_lvl = 1'b0;
    int ph = 0;

    always #2 clk = ~clk;

    pulse_rate_digitizer #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_len(gate_len),
        .count_out(count_out), .count_valid(count_valid), .count_ovf(count_ovf)
    );

    // pulse source: whole-clock periods, updated on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (per_clk == 0) begin
                pulse_in <= hold_lvl;
                ph = 0;
            end else begin
                ph = (ph + 1 >= per_clk) ? 0 : ph + 1;
                pulse_in <= (ph < per_clk / 2);
            end
        end
    end

    localparam int NV = 7;
    localparam int TG [NV] = '{100, 60, 64, 510, 512, 200, 40};
    localparam int TP [NV] = '{  4,  3,  8,   2,   2,  10,  0};
    localparam int TE [NV] = '{ 25, 20,  8, 255, 255,  20,  0};
    localparam int TO [NV] = '{  0,  0,  0,   0,   1,   0,  0};

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!count_valid && n < WD);
        if (!count_valid) begin
            nerr++;
            nchk++;
            $display("FAIL timeout: actual=no strobe expected=strobe");
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n, a, b;
        logic [CNT_W-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 count_out in reset", int'(count_out), 0);
        chk("R1 valid in reset", int'(count_valid), 0);
        chk("R1 ovf in reset", int'(count_ovf), 0);
        rst_n = 1'b1;
        wait_valid(n);
        chk("R1 first strobe delay", n, 21);

        // table walk: R5, R7, R8, R3 window length
        for (int i = 0; i < NV; i++) begin
            gate_len = GATE_W'(TG[i]);
            per_clk  = TP[i];
            hold_lvl = 1'b0;
            wait_valid(n);
            wait_valid(n);
            chk("R3 window length", n, TG[i]);
            chk((TO[i] != 0) ? "R8 saturated count" : (TG[i] == 510 ? "R7 full scale" : "R5 count"),
                int'(count_out), TE[i]);
            chk((TO[i] != 0) ? "R8 ovf set" : "R8 ovf clear", int'(count_ovf), TO[i]);
        end

        // R4: strobe one cycle, outputs held between strobes
        gate_len = GATE_W'(100);
        per_clk  = 4;
        wait_valid(n);
        wait_valid(n);
        held = count_out;
        @(negedge clk);
        chk("R4 strobe width", int'(count_valid), 0);
        repeat (50) @(negedge clk);
        chk("R4 count held", int'(count_out), int'(held));

        // R6 / R9: non-dividing period, truncation and boundary integrity
        gate_len = GATE_W'(510);
        per_clk  = 20;
        wait_valid(n);
        wait_valid(n);
        wait_valid(n);
        a = int'(count_out);
        wait_valid(n);
        b = int'(count_out);
        chk("R6 window a in {25,26}", (a == 25 || a == 26) ? 1 : 0, 1);
        chk("R6 window b in {25,26}", (b == 25 || b == 26) ? 1 : 0, 1);
        chk("R9 two-window sum", a + b, 51);

        // R2: level held high counts once
        gate_len = GATE_W'(40);
        per_clk  = 0;
        hold_lvl = 1'b0;
        wait_valid(n);
        wait_valid(n);
        hold_lvl = 1'b1;
        wait_valid(n);
        chk("R2 held high first window", int'(count_out), 1);
        wait_valid(n);
        chk("R2 held high next window", int'(count_out), 0);
        hold_lvl = 1'b0;
        wait_valid(n);
        wait_valid(n);
        chk("R2 falling edge not counted", int'(count_out), 0);

        // R10: mid-window change applies to the next window
        gate_len = GATE_W'(50);
        wait_valid(n);
        wait_valid(n);
        repeat (10) @(negedge clk);
        gate_len = GATE_W'(30);
        wait_valid(n);
        chk("R10 current window unchanged", n + 10, 50);
        wait_valid(n);
        chk("R10 next window new length", n, 30);

        // R3: zero and one gate lengths
        gate_len = '0;
        wait_valid(n);
        wait_valid(n);
        chk("R3 gate 0 as 1", n, 1);
        gate_len = GATE_W'(1);
        wait_valid(n);
        wait_valid(n);
        chk("R3 gate 1 length", n, 1);
        @(negedge clk);
        chk("R3 gate 1 strobe every cycle", int'(count_valid), 1);

        // R1: reset during operation
        gate_len = GATE_W'(20);
        per_clk  = 2;
        wait_valid(n);
        wait_valid(n);
        rst_n = 1'b0;
        #1;
        chk("R1 count_out on reset", int'(count_out), 0);
        chk("R1 valid on reset", int'(count_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_valid(n);
        chk("R1 restart delay", n, 21);

        finish_run();
    end
endmodule